// File: doc/BRIEF.md
# Inter-core Doorbell Message Unit

This block lets any core in a small cluster ring a doorbell on other cores, and lets each core acknowledge its own doorbells. A send operation presents one register operand. That operand holds three fields: a message type, a broadcast flag and a processor-ID tag. The unit decodes the type into one of two doorbell classes, normal or critical. It works out which cores are addressed and sets that class's pending bit in each of them. Each addressed core also gets a one-cycle hard-interrupt pulse.

A clear operation names the issuing core and carries an operand of the same layout. Only the type field of that operand matters. The clear drops the issuing core's pending bit of the decoded class. Guest message types and any unassigned type code decode to nothing, so the operation is dropped without trace. Each core's processor ID arrives on an input bus, so firmware or straps outside the block own those values. Interrupt arbitration and delivery beyond the pulse belong to the cores.

Top module: `dbell_msg_unit`

## Requirements
- R1: While reset (rstN low) is held and on leaving it, all pending bits and all interrupt pulses are 0.
- R2: A send whose type field (operand bits [31:27]) holds 0 sets the normal pending bit of every addressed core at the next clock edge. A send with type 1 sets the critical pending bit instead.
- R3: A core is addressed when operand bit 26 (broadcast) is 1, or when its processor ID (coreIdFlat[i*14 +: 14]) equals the tag in operand bits [13:0]. Every core with a matching ID is addressed, including cores that share an ID.
- R4: hardIrqPulse[i] is 1 for exactly the one cycle after a live send that addresses core i. It is 0 in every other cycle, including after a send that addresses no core.
- R5: A send with type 2, 3 or 4 (guest classes) or any type code from 5 to 31 changes no pending bit and raises no pulse.
- R6: A clear with type 0 or 1 resets only the pending bit of that class for the core named by clearCore. All other bits are left unchanged.
- R7: A clear whose type is 2 or higher changes no pending bit.
- R8: When a send sets a pending bit and a clear resets the same bit in the same cycle, the bit ends up set.
- R9: Pending bits hold their value until a clear resets them. A send to a core whose bit is already set still produces a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sendValid | input | 1 | A send operation is presented this cycle |
| sendOperand | input | 32 | Send operand: type [31:27], broadcast [26], tag [13:0] |
| clearValid | input | 1 | A clear operation is presented this cycle |
| clearCore | input | 2 | Index of the core issuing the clear |
| clearOperand | input | 32 | Clear operand, only type [31:27] is used |
| coreIdFlat | input | 56 | Processor ID of each core, 14 bits per core, core 0 lowest |
| pendNormal | output | 4 | Normal doorbell pending bit per core |
| pendCrit | output | 4 | Critical doorbell pending bit per core |
| hardIrqPulse | output | 4 | One-cycle hard-interrupt request per core |

## Verification
The pending bits are visible on the ports. A wrong set or clear of any bit therefore shows up on pendNormal or pendCrit one clock edge after the operation that caused it. A stray or missing decode of the target set also shows on hardIrqPulse at that same edge. Such an error can disappear by the next cycle, so every check samples in the cycle right after the operation. The harder cases need sampling at that exact cycle: shared processor IDs, broadcast combined with a non-matching tag, guest type codes, and a send and a clear landing on one bit together.

// File: rtl/dbell_pkg.sv
package dbell_pkg;

  // Message type codes carried in the operand type field
  localparam int CODE_DBELL      = 0;
  localparam int CODE_DBELL_CRIT = 1;
  localparam int CODE_GUEST      = 2;
  localparam int CODE_GUEST_CRIT = 3;
  localparam int CODE_GUEST_MC   = 4;

  // Decoded doorbell class
  typedef enum logic [1:0] {
    KIND_NONE   = 2'd0,
    KIND_NORMAL = 2'd1,
    KIND_CRIT   = 2'd2
  } dbKind_e;

  // Per-core strobes handed from control to datapath
  typedef struct packed {
    logic setNorm;
    logic setCrit;
    logic clrNorm;
    logic clrCrit;
  } coreStrobe_t;

endpackage

// File: rtl/dbell_ctrl.sv
module dbell_ctrl
  import dbell_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int OP_W      = 32,
  parameter int TAG_W     = 14,
  parameter int TYPE_W    = 5,
  parameter int TYPE_LSB  = 27,
  parameter int BCAST_POS = 26,
  localparam int CORE_IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                       sendValid,
  input  logic [OP_W-1:0]            sendOperand,
  input  logic                       clearValid,
  input  logic [CORE_IDX_W-1:0]      clearCore,
  input  logic [OP_W-1:0]            clearOperand,
  input  logic [NUM_CORES*TAG_W-1:0] coreIdFlat,
  output coreStrobe_t                strobes [NUM_CORES]
);

  // Maps a type code to a doorbell class; guest and unassigned codes give none
  function automatic dbKind_e decodeKind(input logic [TYPE_W-1:0] code);
    dbKind_e kind;
    kind = KIND_NONE;
    if (code == TYPE_W'(CODE_DBELL))      kind = KIND_NORMAL;
    if (code == TYPE_W'(CODE_DBELL_CRIT)) kind = KIND_CRIT;
    return kind;
  endfunction

  logic [TYPE_W-1:0] sendType;
  logic [TYPE_W-1:0] clearType;
  logic [TAG_W-1:0]  sendTag;
  logic              sendBcast;
  dbKind_e           sendKind;
  dbKind_e           clearKind;
  logic              sendLive;
  logic              clearLive;
  logic              unusedOperandBits;

  assign sendType  = sendOperand[TYPE_LSB +: TYPE_W];
  assign clearType = clearOperand[TYPE_LSB +: TYPE_W];
  assign sendTag   = sendOperand[TAG_W-1:0];
  assign sendBcast = sendOperand[BCAST_POS];

  assign sendKind  = decodeKind(sendType);
  assign clearKind = decodeKind(clearType);

  assign sendLive  = sendValid  && (sendKind  != KIND_NONE);
  assign clearLive = clearValid && (clearKind != KIND_NONE);

  // Reserved operand bits carry no meaning for this unit
  assign unusedOperandBits = ^{sendOperand, clearOperand};

  for (genvar coreIdx = 0; coreIdx < NUM_CORES; coreIdx++) begin : g_core
    logic idMatch;
    logic targeted;
    logic isIssuer;

    assign idMatch  = (coreIdFlat[coreIdx*TAG_W +: TAG_W] == sendTag);
    assign targeted = sendLive && (sendBcast || idMatch);
    assign isIssuer = clearLive && (clearCore == CORE_IDX_W'(coreIdx));

    always_comb begin
      strobes[coreIdx].setNorm = targeted && (sendKind == KIND_NORMAL);
      strobes[coreIdx].setCrit = targeted && (sendKind == KIND_CRIT);
      strobes[coreIdx].clrNorm = isIssuer && (clearKind == KIND_NORMAL);
      strobes[coreIdx].clrCrit = isIssuer && (clearKind == KIND_CRIT);
    end
  end

endmodule

// File: rtl/dbell_datapath.sv
module dbell_datapath
  import dbell_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  coreStrobe_t          strobes [NUM_CORES],
  output logic [NUM_CORES-1:0] pendNormal,
  output logic [NUM_CORES-1:0] pendCrit,
  output logic [NUM_CORES-1:0] hardIrqPulse
);

  for (genvar coreIdx = 0; coreIdx < NUM_CORES; coreIdx++) begin : g_core
    logic normNext;
    logic critNext;
    logic irqNext;

    // A set in the same cycle overrides a clear of the same bit
    assign normNext = strobes[coreIdx].setNorm ||
                      (pendNormal[coreIdx] && !strobes[coreIdx].clrNorm);
    assign critNext = strobes[coreIdx].setCrit ||
                      (pendCrit[coreIdx] && !strobes[coreIdx].clrCrit);
    assign irqNext  = strobes[coreIdx].setNorm || strobes[coreIdx].setCrit;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pendNormal[coreIdx]   <= 1'b0;
        pendCrit[coreIdx]     <= 1'b0;
        hardIrqPulse[coreIdx] <= 1'b0;
      end else begin
        pendNormal[coreIdx]   <= normNext;
        pendCrit[coreIdx]     <= critNext;
        hardIrqPulse[coreIdx] <= irqNext;
      end
    end
  end

endmodule

// File: rtl/dbell_msg_unit.sv
module dbell_msg_unit
  import dbell_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int OP_W      = 32,
  parameter int TAG_W     = 14,
  parameter int TYPE_W    = 5,
  parameter int TYPE_LSB  = 27,
  parameter int BCAST_POS = 26,
  localparam int CORE_IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sendValid,
  input  logic [OP_W-1:0]            sendOperand,
  input  logic                       clearValid,
  input  logic [CORE_IDX_W-1:0]      clearCore,
  input  logic [OP_W-1:0]            clearOperand,
  input  logic [NUM_CORES*TAG_W-1:0] coreIdFlat,
  output logic [NUM_CORES-1:0]       pendNormal,
  output logic [NUM_CORES-1:0]       pendCrit,
  output logic [NUM_CORES-1:0]       hardIrqPulse
);

  coreStrobe_t strobes [NUM_CORES];

  dbell_ctrl #(
    .NUM_CORES(NUM_CORES),
    .OP_W     (OP_W),
    .TAG_W    (TAG_W),
    .TYPE_W   (TYPE_W),
    .TYPE_LSB (TYPE_LSB),
    .BCAST_POS(BCAST_POS)
  ) ctrl_i (
    .sendValid   (sendValid),
    .sendOperand (sendOperand),
    .clearValid  (clearValid),
    .clearCore   (clearCore),
    .clearOperand(clearOperand),
    .coreIdFlat  (coreIdFlat),
    .strobes     (strobes)
  );

  dbell_datapath #(
    .NUM_CORES(NUM_CORES)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .pendNormal  (pendNormal),
    .pendCrit    (pendCrit),
    .hardIrqPulse(hardIrqPulse)
  );

endmodule

// File: rtl/dbell_msg_unit_chk.sv
module dbell_msg_unit_chk #(
  parameter int NUM_CORES = 4,
  parameter int OP_W      = 32,
  parameter int TAG_W     = 14,
  parameter int TYPE_W    = 5,
  parameter int TYPE_LSB  = 27,
  parameter int BCAST_POS = 26,
  localparam int CORE_IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       sendValid,
  input logic [OP_W-1:0]            sendOperand,
  input logic                       clearValid,
  input logic [CORE_IDX_W-1:0]      clearCore,
  input logic [OP_W-1:0]            clearOperand,
  input logic [NUM_CORES*TAG_W-1:0] coreIdFlat,
  input logic [NUM_CORES-1:0]       pendNormal,
  input logic [NUM_CORES-1:0]       pendCrit,
  input logic [NUM_CORES-1:0]       hardIrqPulse
);

  logic [TYPE_W-1:0]    sendType;
  logic                 sendBcast;
  logic                 sendIsLive;
  logic [NUM_CORES-1:0] issuerMask;
  logic                 unusedChkBits;

  assign sendType   = sendOperand[TYPE_LSB +: TYPE_W];
  assign sendBcast  = sendOperand[BCAST_POS];
  assign sendIsLive = (sendType == TYPE_W'(0)) || (sendType == TYPE_W'(1));
  assign issuerMask = NUM_CORES'(1) << clearCore;
  assign unusedChkBits = ^{sendOperand, clearOperand, coreIdFlat};

  // R4: a pulse only appears on a core that now holds a pending doorbell
  p_irq_has_pending_r4: assert property (@(posedge clk) disable iff (!rstN)
    (hardIrqPulse & ~(pendNormal | pendCrit)) == '0);

  // R4: no pulse follows a cycle without a send
  p_idle_no_irq_r4: assert property (@(posedge clk) disable iff (!rstN)
    !sendValid |=> hardIrqPulse == '0);

  // R5: guest and unassigned types leave everything untouched
  p_ignored_type_r5: assert property (@(posedge clk) disable iff (!rstN)
    (sendValid && !sendIsLive && !clearValid) |=>
      ($stable(pendNormal) && $stable(pendCrit) && hardIrqPulse == '0));

  // R3: broadcast normal doorbell reaches every core
  p_bcast_all_r3: assert property (@(posedge clk) disable iff (!rstN)
    (sendValid && sendBcast && sendType == TYPE_W'(0)) |=>
      ((&pendNormal) && (&hardIrqPulse)));

  // R6: a clear alone touches no core other than the issuer
  p_clear_local_r6: assert property (@(posedge clk) disable iff (!rstN)
    (clearValid && !sendValid) |=>
      ((((pendNormal ^ $past(pendNormal)) | (pendCrit ^ $past(pendCrit)))
        & ~$past(issuerMask)) == '0));

  // R8: broadcast critical send beats a same-cycle clear
  p_send_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    (sendValid && clearValid && sendBcast && sendType == TYPE_W'(1)) |=>
      (&pendCrit));

  // R9: with no operation the pending state holds
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!sendValid && !clearValid) |=> ($stable(pendNormal) && $stable(pendCrit)));

endmodule

bind dbell_msg_unit dbell_msg_unit_chk #(
  .NUM_CORES(NUM_CORES),
  .OP_W     (OP_W),
  .TAG_W    (TAG_W),
  .TYPE_W   (TYPE_W),
  .TYPE_LSB (TYPE_LSB),
  .BCAST_POS(BCAST_POS)
) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .sendValid   (sendValid),
  .sendOperand (sendOperand),
  .clearValid  (clearValid),
  .clearCore   (clearCore),
  .clearOperand(clearOperand),
  .coreIdFlat  (coreIdFlat),
  .pendNormal  (pendNormal),
  .pendCrit    (pendCrit),
  .hardIrqPulse(hardIrqPulse)
);

// File: tb/dbell_msg_unit_tb_top.sv
`timescale 1ns/1ps
module dbell_msg_unit_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sendValid = 1'b0;
  logic [31:0] sendOperand = '0;
  logic        clearValid = 1'b0;
  logic [1:0]  clearCore = '0;
  logic [31:0] clearOperand = '0;
  logic [55:0] coreIdFlat;
  logic [3:0]  pendNormal;
  logic [3:0]  pendCrit;
  logic [3:0]  hardIrqPulse;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  // Core IDs: core0 0x0000, cores 1 and 2 share 0x0055, core3 0x3FFF
  assign coreIdFlat = {14'h3FFF, 14'h0055, 14'h0055, 14'h0000};

  dbell_msg_unit dut_i (
    .clk(clk), .rstN(rstN),
    .sendValid(sendValid), .sendOperand(sendOperand),
    .clearValid(clearValid), .clearCore(clearCore), .clearOperand(clearOperand),
    .coreIdFlat(coreIdFlat),
    .pendNormal(pendNormal), .pendCrit(pendCrit), .hardIrqPulse(hardIrqPulse)
  );

  function automatic logic [31:0] mkOp(input int typ, input bit bcast, input logic [13:0] tag);
    return {typ[4:0], bcast, 12'h000, tag};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic chkAll(input string req, input logic [3:0] eNorm,
                        input logic [3:0] eCrit, input logic [3:0] eIrq);
    chk(req, "pendNormal", pendNormal, eNorm);
    chk(req, "pendCrit", pendCrit, eCrit);
    chk(req, "hardIrqPulse", hardIrqPulse, eIrq);
  endtask

  // Present one operation for one cycle; returns at the following negedge
  task automatic doOp(input bit sv, input logic [31:0] sop,
                      input bit cv, input logic [1:0] core, input logic [31:0] cop);
    @(negedge clk);
    sendValid = sv; sendOperand = sop;
    clearValid = cv; clearCore = core; clearOperand = cop;
    @(negedge clk);
    sendValid = 1'b0; clearValid = 1'b0;
  endtask

  task automatic testReset();
    chkAll("R1", 4'b0000, 4'b0000, 4'b0000);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    chkAll("R1", 4'b0000, 4'b0000, 4'b0000);
  endtask

  task automatic testDirectedSend();
    doOp(1, mkOp(0, 0, 14'h0000), 0, 0, 0);
    chkAll("R2", 4'b0001, 4'b0000, 4'b0001);
    @(negedge clk);
    chk("R4", "pulse one cycle", hardIrqPulse, 4'b0000);
    doOp(1, mkOp(1, 0, 14'h0055), 0, 0, 0);
    chkAll("R3", 4'b0001, 4'b0110, 4'b0110);
  endtask

  task automatic testNoMatch();
    doOp(1, mkOp(0, 0, 14'h0777), 0, 0, 0);
    chkAll("R4", 4'b0001, 4'b0110, 4'b0000);
  endtask

  task automatic testIgnoredTypes();
    int codes [5] = '{2, 3, 4, 9, 31};
    foreach (codes[k]) begin
      doOp(1, mkOp(codes[k], 1, 14'h0055), 0, 0, 0);
      chkAll("R5", 4'b0001, 4'b0110, 4'b0000);
    end
  endtask

  task automatic testBroadcast();
    doOp(1, mkOp(0, 1, 14'h0777), 0, 0, 0);
    chkAll("R3", 4'b1111, 4'b0110, 4'b1111);
  endtask

  task automatic testClear();
    doOp(0, 0, 1, 2'd2, mkOp(0, 0, 14'h0000));
    chkAll("R6", 4'b1011, 4'b0110, 4'b0000);
    doOp(0, 0, 1, 2'd1, mkOp(1, 1, 14'h3FFF));
    chkAll("R6", 4'b1011, 4'b0100, 4'b0000);
  endtask

  task automatic testIgnoredClear();
    int codes [4] = '{2, 3, 4, 7};
    foreach (codes[k]) begin
      doOp(0, 0, 1, 2'd0, mkOp(codes[k], 0, 14'h0000));
      chkAll("R7", 4'b1011, 4'b0100, 4'b0000);
    end
  endtask

  task automatic testSendWins();
    doOp(0, 0, 1, 2'd3, mkOp(0, 0, 14'h0000));
    chkAll("R6", 4'b0011, 4'b0100, 4'b0000);
    doOp(1, mkOp(0, 0, 14'h3FFF), 1, 2'd3, mkOp(0, 0, 14'h0000));
    chkAll("R8", 4'b1011, 4'b0100, 4'b1000);
    doOp(1, mkOp(1, 0, 14'h3FFF), 1, 2'd0, mkOp(0, 0, 14'h0000));
    chkAll("R8", 4'b1010, 4'b1100, 4'b1000);
  endtask

  task automatic testSticky();
    doOp(1, mkOp(1, 0, 14'h3FFF), 0, 0, 0);
    chkAll("R9", 4'b1010, 4'b1100, 4'b1000);
    repeat (3) @(negedge clk);
    chkAll("R9", 4'b1010, 4'b1100, 4'b0000);
  endtask

  initial begin
    testReset();
    testDirectedSend();
    testNoMatch();
    testIgnoredTypes();
    testBroadcast();
    testClear();
    testIgnoredClear();
    testSendWins();
    testSticky();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule